// File: doc/BRIEF.md
# GPIO Edge Event Status Logic

This block watches the input pins of a small general-purpose I/O port (four to eight pins, six by default) and records edges on them. Every pin runs through a two-stage synchronizer. The synchronized value is then compared with the sample from the previous cycle. A two-bit sense field per pin chooses what counts as an event: nothing, a rising edge, a falling edge, or either edge. When a selected edge is seen, the pin's status bit is set and stays set. If the pin is not masked, its interrupt-source bit is set as well, and the shared active-low interrupt output goes low.

Software uses a plain register port with a write strobe, an address and write data, plus a combinational read-data output. It clears pending events by writing ones to the status register. That write clears both the status bit and the interrupt-source bit of each selected pin. When a pin's sense field is changed, that pin's pending status and source bits are dropped automatically.

Top module: `gpio_edge_evt`

## Requirements
- R1: After a synchronous active-low reset, the following hold. The mask register (address 0) reads ones in every pin bit. Both sense registers (addresses 1 and 2) read 0. The interrupt-source register (address 3) reads 0. The status register (address 4) reads 0. irq_n_o is 1.
- R2: Each pin has a sense field with these codes: 00 means no events, 01 means rising edge, 10 means falling edge, 11 means either edge. The field for pin p < 4 sits at bits 2p+1:2p of address 1. The field for pin p >= 4 sits at bits 2(p-4)+1:2(p-4) of address 2. A status bit (bit p of address 4) is set only by the edge its field selects. It becomes readable at most three clock edges after the pin changes.
- R3: A status bit stays set after the pin returns to its earlier level, until software clears it.
- R4: An interrupt-source bit (bit p of address 3) is set only when an event occurs on pin p while mask bit p (address 0) is 0. A mask bit of 1 blocks it. A source bit is never set while its status bit is clear.
- R5: irq_n_o is 0 exactly while at least one interrupt-source bit is 1.
- R6: A write to address 4 clears the status bit and the interrupt-source bit of every pin whose data bit is 1. Data bits that are 0 leave their pins unchanged.
- R7: A write to a sense register that changes a pin's field clears that pin's status and interrupt-source bits. Writing the same field value clears nothing.
- R8: Register bits above the last pin read 0. In the sense registers, this means fields of pins that do not exist.
- R9: If an edge event and a write-one-to-clear hit the same bit on the same clock edge, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | NUM_PINS | Asynchronous pin levels |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read data, combinational on addr_i |
| irq_n_o | output | 1 | Active-low interrupt, low while any source bit is set |

## Verification
A wrong sense decode or a broken synchronizer shows up at address 4 within three clock edges of a pin change. It appears either as a missing bit or as a bit set by the edge that was not selected. A stuck or wrongly cleared status or source bit stays visible at the register port and on irq_n_o until the next clear. A sticky-state error is therefore visible on the very next read. Priority mistakes between set and clear appear in the cycle right after the collision, as a status bit that has gone to 0.

// File: rtl/gpio_evt_pkg.sv
// Shared constants and types for the GPIO edge event block.
// Assumes an 8-bit register port with a 3-bit address.
package gpio_evt_pkg;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] A_MASK     = 3'd0;
    localparam logic [ADDR_W-1:0] A_SENSE_LO = 3'd1;
    localparam logic [ADDR_W-1:0] A_SENSE_HI = 3'd2;
    localparam logic [ADDR_W-1:0] A_SRC      = 3'd3;
    localparam logic [ADDR_W-1:0] A_STATUS   = 3'd4;

    localparam int PINS_PER_SENSE = 4;

    typedef enum logic [1:0] {
        SNS_OFF  = 2'b00,
        SNS_RISE = 2'b01,
        SNS_FALL = 2'b10,
        SNS_ANY  = 2'b11
    } sense_t;
endpackage

// File: rtl/gpio_evt_sync.sv
// Multi-stage synchronizer for a bus of independent asynchronous bits.
// Assumes each bit is sampled on its own; no bus coherency is implied.
// Resets every stage to 0.
module gpio_evt_sync #(
    parameter int WIDTH  = 6,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the asynchronous input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_evt_edge.sv
// Per-pin edge detector.
// Compares the synchronized sample with the sample from the previous
// cycle and applies the pin's 2-bit sense code. The previous sample
// resets to 0, so a pin already high when reset is released reports a
// rising edge one cycle after its synchronized value arrives.
module gpio_evt_edge
    import gpio_evt_pkg::*;
#(
    parameter int NUM_PINS = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PINS-1:0]   sample_i,
    input  logic [2*NUM_PINS-1:0] sense_i,
    output logic [NUM_PINS-1:0]   hit_o
);
    logic [NUM_PINS-1:0] prev_q;

    // Keep last cycle's synchronized level for comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sample_i;
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic rise, fall, hit_p;
        assign rise = sample_i[p] & ~prev_q[p];
        assign fall = ~sample_i[p] & prev_q[p];

        // Select which edge of this pin counts as an event.
        always_comb begin
            case (sense_t'(sense_i[2*p +: 2]))
                SNS_RISE: hit_p = rise;
                SNS_FALL: hit_p = fall;
                SNS_ANY:  hit_p = rise | fall;
                default:  hit_p = 1'b0;
            endcase
        end
        assign hit_o[p] = hit_p;
    end
endmodule

// File: rtl/gpio_edge_evt.sv
// GPIO edge event status block: register file, sticky status, masked
// interrupt sources and the active-low interrupt output.
// Assumes 4 <= NUM_PINS <= 8 and an 8-bit register port. A set from a
// new edge takes priority over any clear on the same bit and clock.
module gpio_edge_evt
    import gpio_evt_pkg::*;
#(
    parameter int NUM_PINS    = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic                wr_en_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [DATA_W-1:0]   wr_data_i,
    output logic [DATA_W-1:0]   rd_data_o,
    output logic                irq_n_o
);
    localparam int SENSE_W = 2 * NUM_PINS;

    logic [NUM_PINS-1:0] pin_sync;
    logic [NUM_PINS-1:0] hit_w;
    logic [SENSE_W-1:0]  sense_q;
    logic [SENSE_W-1:0]  sense_new;
    logic [NUM_PINS-1:0] sense_we;
    logic [NUM_PINS-1:0] sense_chg;
    logic [NUM_PINS-1:0] mask_q;
    logic [NUM_PINS-1:0] status_q;
    logic [NUM_PINS-1:0] src_q;
    logic [NUM_PINS-1:0] clr_w1c;
    logic [NUM_PINS-1:0] clr_all;

    gpio_evt_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_i),
        .q_o   (pin_sync)
    );

    gpio_evt_edge #(.NUM_PINS(NUM_PINS)) i_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_i (pin_sync),
        .sense_i  (sense_q),
        .hit_o    (hit_w)
    );

    // Per-pin sense write decode and change detection.
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_sense
        localparam int SLOT = p % PINS_PER_SENSE;
        localparam logic [ADDR_W-1:0] MY_ADDR =
            (p < PINS_PER_SENSE) ? A_SENSE_LO : A_SENSE_HI;
        assign sense_we[p]          = wr_en_i && (addr_i == MY_ADDR);
        assign sense_new[2*p +: 2]  = wr_data_i[2*SLOT +: 2];
        assign sense_chg[p]         = sense_we[p] &&
                                      (sense_new[2*p +: 2] != sense_q[2*p +: 2]);
    end

    // Hold the sense fields; each pin field updates from its own register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sense_q <= '0;
        end else begin
            for (int p = 0; p < NUM_PINS; p++)
                if (sense_we[p]) sense_q[2*p +: 2] <= sense_new[2*p +: 2];
        end
    end

    // Hold the interrupt mask; a 1 blocks the pin's interrupt source.
    always_ff @(posedge clk) begin
        if (!rst_n)                             mask_q <= '1;
        else if (wr_en_i && addr_i == A_MASK)   mask_q <= wr_data_i[NUM_PINS-1:0];
    end

    assign clr_w1c = (wr_en_i && addr_i == A_STATUS) ? wr_data_i[NUM_PINS-1:0] : '0;
    assign clr_all = clr_w1c | sense_chg;

    // Sticky status and source bits; a new edge overrides any clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            src_q    <= '0;
        end else begin
            status_q <= (status_q & ~clr_all) | hit_w;
            src_q    <= (src_q & ~clr_all) | (hit_w & ~mask_q);
        end
    end

    assign irq_n_o = ~|src_q;

    // Combinational register read; absent bits read 0.
    always_comb begin
        rd_data_o = '0;
        case (addr_i)
            A_MASK:   rd_data_o[NUM_PINS-1:0] = mask_q;
            A_SRC:    rd_data_o[NUM_PINS-1:0] = src_q;
            A_STATUS: rd_data_o[NUM_PINS-1:0] = status_q;
            A_SENSE_LO: begin
                for (int p = 0; p < NUM_PINS; p++)
                    if (p < PINS_PER_SENSE)
                        rd_data_o[2*(p % PINS_PER_SENSE) +: 2] = sense_q[2*p +: 2];
            end
            A_SENSE_HI: begin
                for (int p = 0; p < NUM_PINS; p++)
                    if (p >= PINS_PER_SENSE)
                        rd_data_o[2*(p % PINS_PER_SENSE) +: 2] = sense_q[2*p +: 2];
            end
            default: rd_data_o = '0;
        endcase
    end

    AST_SRC_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (src_q & ~status_q) == '0); // R4

    AST_MASK_BLOCKS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((src_q & ~$past(src_q) & $past(mask_q)) == '0)); // R4

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit_w) |=> ((status_q & $past(hit_w)) == $past(hit_w))); // R9

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == A_STATUS) |=>
            ((status_q & $past(wr_data_i[NUM_PINS-1:0] & ~hit_w)) == '0)); // R6

    // Status reads never show bits beyond the last pin.
    always_comb begin
        if (rst_n && addr_i == A_STATUS)
            AST_STATUS_UPPER_ZERO: assert ((rd_data_o >> NUM_PINS) == '0); // R8
    end
endmodule

// File: tb/test_gpio_edge_evt.sv
`timescale 1ns/1ps
module test_gpio_edge_evt;
    import gpio_evt_pkg::*;

    localparam int NP = 6;

    logic             clk   = 1'b0;
    logic             rst_n = 1'b0;
    logic [NP-1:0]    pin   = '0;
    logic             wr_en = 1'b0;
    logic [2:0]       addr  = '0;
    logic [7:0]       wdata = '0;
    logic [7:0]       rdata;
    logic             irq_n;

    int errs   = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    gpio_edge_evt #(.NUM_PINS(NP)) i_gpio_edge_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (pin),
        .wr_en_i   (wr_en),
        .addr_i    (addr),
        .wr_data_i (wdata),
        .rd_data_o (rdata),
        .irq_n_o   (irq_n)
    );

    typedef struct packed {
        logic [7:0] slo, shi, mask, pb, pa, est, esrc;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{8'h55, 8'h05, 8'h00, 8'h00, 8'h2A, 8'h2A, 8'h2A}, // R2 rising, unmasked
        '{8'hAA, 8'h0A, 8'h0F, 8'h3F, 8'h30, 8'h0F, 8'h00}, // R2 falling, R4 masked
        '{8'hFF, 8'h0F, 8'h30, 8'h15, 8'h2A, 8'h3F, 8'h0F}, // R2 both, R4 partial mask
        '{8'h00, 8'h00, 8'h00, 8'h00, 8'h3F, 8'h00, 8'h00}, // R2 none
        '{8'h39, 8'h09, 8'h00, 8'h2A, 8'h15, 8'h37, 8'h37}, // R2 mixed per pin
        '{8'h55, 8'h05, 8'h00, 8'h3F, 8'h00, 8'h00, 8'h00}  // R2 rising ignores falls
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic check_reg(input string req, input logic [2:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        tick(4);
        rst_n = 1'b1;
        tick(1);

        // R1 reset state
        check_reg("R1 mask", A_MASK, 8'h3F);
        check_reg("R1 sense lo", A_SENSE_LO, 8'h00);
        check_reg("R1 sense hi", A_SENSE_HI, 8'h00);
        check_reg("R1 src", A_SRC, 8'h00);
        check_reg("R1 status", A_STATUS, 8'h00);
        check("R1 irq_n", {7'd0, irq_n}, 8'h01);

        // Vector table: R2, R4, R5
        for (int i = 0; i < 6; i++) begin
            wr(A_SENSE_LO, VECS[i].slo);
            wr(A_SENSE_HI, VECS[i].shi);
            wr(A_MASK, VECS[i].mask);
            pin = VECS[i].pb[NP-1:0];
            tick(6);
            wr(A_STATUS, 8'h3F);
            pin = VECS[i].pa[NP-1:0];
            tick(6);
            check_reg($sformatf("R2 status vec%0d", i), A_STATUS, VECS[i].est);
            check_reg($sformatf("R4 src vec%0d", i), A_SRC, VECS[i].esrc);
            check($sformatf("R5 irq_n vec%0d", i), {7'd0, irq_n},
                  {7'd0, VECS[i].esrc == 8'h00});
        end

        // R3 sticky after pin returns
        wr(A_SENSE_LO, 8'h01);
        wr(A_SENSE_HI, 8'h00);
        wr(A_MASK, 8'h00);
        pin = '0;
        tick(6);
        wr(A_STATUS, 8'h3F);
        pin = 6'h01;
        tick(6);
        pin = 6'h00;
        tick(6);
        check_reg("R3 sticky status", A_STATUS, 8'h01);
        check("R5 irq low", {7'd0, irq_n}, 8'h00);

        // R6 write-one-to-clear
        wr(A_STATUS, 8'h00);
        check_reg("R6 zero write keeps status", A_STATUS, 8'h01);
        check_reg("R6 zero write keeps src", A_SRC, 8'h01);
        wr(A_STATUS, 8'h01);
        check_reg("R6 clear status", A_STATUS, 8'h00);
        check_reg("R6 clear src", A_SRC, 8'h00);
        check("R6 irq released", {7'd0, irq_n}, 8'h01);

        // R7 sense change clears, same value does not
        pin = 6'h01;
        tick(6);
        wr(A_SENSE_LO, 8'h01);
        check_reg("R7 same sense keeps status", A_STATUS, 8'h01);
        wr(A_SENSE_LO, 8'h03);
        check_reg("R7 changed sense clears status", A_STATUS, 8'h00);
        check_reg("R7 changed sense clears src", A_SRC, 8'h00);

        // R8 absent bits read zero
        wr(A_SENSE_HI, 8'hFF);
        check_reg("R8 sense hi upper", A_SENSE_HI, 8'h0F);
        wr(A_SENSE_HI, 8'h00);
        wr(A_MASK, 8'hFF);
        check_reg("R8 mask upper", A_MASK, 8'h3F);
        wr(A_MASK, 8'h00);

        // R9 set wins over a clear on the same edge (pin0 senses both edges)
        pin = 6'h00;
        tick(6);
        check_reg("R9 pre-event", A_STATUS, 8'h01);
        pin = 6'h01;
        tick(2);
        wr(A_STATUS, 8'h01);
        check_reg("R9 status kept", A_STATUS, 8'h01);
        check_reg("R9 src kept", A_SRC, 8'h01);
        wr(A_STATUS, 8'h01);
        check_reg("R6 later clear", A_STATUS, 8'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule